// File: doc/BRIEF.md
# Paged Address Translation Unit

This block converts the virtual addresses a processor issues into physical addresses, using pages of 4 KB. The low 12 bits of an address are the offset within the page and pass through unchanged. The bits above them form the virtual page number. An eight-entry fully associative translation cache is searched first. When it has no match, a hardware walker reads one 32-bit entry from a flat page table in memory, located from a base register, and uses that entry to finish the access.

Every access carries an access kind (read, write or execute) and a privilege flag. The unit compares these with the permission bits of the matching entry, and returns either a physical address or a fault code. The base register can be written only from supervisor mode. A supervisor write, or a pulse on the flush input, empties the translation cache.

Top module: `paged_mmu`

## Requirements
- R1: The physical address is the 20-bit physical page number from the matching entry, placed in bits 31:12, with the request's offset bits 11:0 unchanged.
- R2: A request that matches a cached translation produces no memory read, and `rsp_valid` goes high in the cycle after the accepting edge.
- R3: On a miss, `mem_req` is high for exactly one cycle, starting in the cycle after acceptance, with `mem_addr` = base + 4 × page number. The response appears in the cycle after the edge that samples `mem_rvalid` high.
- R4: A walk that returns an entry with its valid bit set loads that translation into the cache, so a later access to the same page needs no walk. An entry with its valid bit clear is never cached.
- R5: An entry with its valid bit clear returns fault code 1 (page fault) and `rsp_paddr` = 0. The page fault takes priority over any protection fault.
- R6: Fault code 2 (protection fault) is returned with `rsp_paddr` = 0 in any of these cases: a user access to an entry without the user bit; a read (kind 0) without the read bit; a write (kind 1) without the write bit; an execute (kind 2) without the execute bit. Fault code 0 means the access succeeded. Code 3 is never produced.
- R7: Layout of a page table entry: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, bits 31:12 physical page number. Bits 11:5 are ignored.
- R8: The cache holds 8 translations. New translations fill the slots in round-robin order starting at slot 0, so the ninth distinct fill evicts the first one.
- R9: A high `flush` at a clock edge invalidates every cached translation.
- R10: A base write with `base_user` = 0 loads the register and invalidates the cache. With `base_user` = 1 the register and the cache are left unchanged, and `base_fault` pulses high for one cycle after the edge.
- R11: `req_ready` is high only while no walk is in progress, so at most one request is outstanding.
- R12: After a synchronous reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req` = 0, `base_fault` = 0, the base register is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_req | output | 1 | Walker read strobe |
| mem_addr | output | 32 | Walker read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page table entry read back |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New base address |
| base_user | input | 1 | Privilege of the base writer, 1 = user |
| base_fault | output | 1 | Rejected base write |
| flush | input | 1 | Invalidate all cached translations |

## Verification
A cache hit responds in the cycle right after the accepting edge. A miss raises `mem_req` in that same cycle instead, and its response comes one cycle after the edge that takes `mem_rvalid`. Each bench access drives its request at a falling edge and samples at the next falling edge. From what it sees there, it decides whether a hit or a walk occurred, then supplies the entry and samples once more a cycle later. A rejected base write is checked half a cycle after the edge that registers it. The assertions check the one-cycle walker strobe and the response that follows read data.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
    localparam int unsigned OFS_W = 12;
    localparam int unsigned PTE_W = 32;
    localparam int unsigned PPN_W = PTE_W - OFS_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } flt_e;

    // Packed so that bit 0 is the valid flag, matching the entry layout.
    typedef struct packed {
        logic usr;
        logic ex;
        logic wr;
        logic rd;
        logic vld;
    } perm_t;

    function automatic perm_t pte_perm(input logic [PTE_W-1:0] pte);
        return perm_t'(pte[4:0]);
    endfunction

    function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] pte);
        return pte[PTE_W-1:OFS_W];
    endfunction

    function automatic flt_e judge(input perm_t p, input logic [1:0] kind, input logic user);
        logic deny;
        if (!p.vld) return FLT_PAGE;
        deny = user && !p.usr;
        case (kind)
            ACC_READ:  deny = deny || !p.rd;
            ACC_WRITE: deny = deny || !p.wr;
            ACC_EXEC:  deny = deny || !p.ex;
            default:   deny = 1'b1;
        endcase
        return deny ? FLT_PROT : FLT_NONE;
    endfunction
endpackage

// File: rtl/mmu_tlb.sv
`timescale 1ns/1ps
module mmu_tlb
    import mmu_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output perm_t            lk_perm,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  perm_t            fill_perm,
    input  logic             flush
);
    localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] slot_vld;
    logic [VPN_W-1:0]   slot_vpn  [ENTRIES];
    logic [PPN_W-1:0]   slot_ppn  [ENTRIES];
    perm_t              slot_perm [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [PTR_W-1:0]   victim;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_vpn[g] == lk_vpn);
    end

    always_comb begin
        lk_hit  = |match;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_ppn  = lk_ppn | slot_ppn[i];
                lk_perm = lk_perm | slot_perm[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
            victim   <= '0;
        end else if (flush) begin
            slot_vld <= '0;
        end else if (fill_en) begin
            slot_vld[victim] <= 1'b1;
            victim <= (victim == PTR_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            slot_vpn[victim]  <= fill_vpn;
            slot_ppn[victim]  <= fill_ppn;
            slot_perm[victim] <= fill_perm;
        end
    end
endmodule

// File: rtl/mmu_base_reg.sv
`timescale 1ns/1ps
module mmu_base_reg #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          wr_user,
    output logic [AW-1:0] base,
    output logic          inval,
    output logic          reject
);
    assign inval = wr_en && !wr_user;

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            reject <= 1'b0;
        end else begin
            reject <= wr_en && wr_user;
            if (inval) base <= wr_data;
        end
    end
endmodule

// File: rtl/mmu_walker.sv
`timescale 1ns/1ps
module mmu_walker
    import mmu_pkg::*;
#(
    parameter int unsigned VA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    input  logic [1:0]          req_kind,
    input  logic                req_user,
    output logic [VA_W-OFS_W-1:0] lk_vpn,
    input  logic                tlb_hit,
    input  logic [PPN_W-1:0]    tlb_ppn,
    input  perm_t               tlb_perm,
    input  logic [PTE_W-1:0]    base,
    output logic                mem_req,
    output logic [PTE_W-1:0]    mem_addr,
    input  logic                mem_rvalid,
    input  logic [PTE_W-1:0]    mem_rdata,
    output logic                fill_en,
    output logic [VA_W-OFS_W-1:0] fill_vpn,
    output logic [PPN_W-1:0]    fill_ppn,
    output perm_t               fill_perm,
    output logic                walk_wait,
    output logic                rsp_valid,
    output logic [PTE_W-1:0]    rsp_paddr,
    output logic [1:0]          rsp_fault
);
    localparam int unsigned VPN_W = VA_W - OFS_W;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [OFS_W-1:0] ofs;
        logic [1:0]       kind;
        logic             user;
    } held_t;

    st_e   st;
    held_t held;
    flt_e  hit_flt, walk_flt;
    perm_t walk_perm;

    assign req_ready = (st == ST_IDLE);
    assign mem_req   = (st == ST_ISSUE);
    assign walk_wait = (st == ST_WAIT);
    assign lk_vpn    = req_vaddr[VA_W-1:OFS_W];

    assign walk_perm = pte_perm(mem_rdata);
    assign hit_flt   = judge(tlb_perm, req_kind, req_user);
    assign walk_flt  = judge(walk_perm, held.kind, held.user);

    assign fill_en   = walk_wait && mem_rvalid && walk_perm.vld;
    assign fill_vpn  = held.vpn;
    assign fill_ppn  = pte_ppn(mem_rdata);
    assign fill_perm = walk_perm;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            held      <= '0;
            mem_addr  <= '0;
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (tlb_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= hit_flt;
                            rsp_paddr <= (hit_flt == FLT_NONE)
                                       ? {tlb_ppn, req_vaddr[OFS_W-1:0]} : '0;
                        end else begin
                            held     <= '{vpn: lk_vpn, ofs: req_vaddr[OFS_W-1:0],
                                          kind: req_kind, user: req_user};
                            mem_addr <= base + PTE_W'({lk_vpn, 2'b00});
                            st       <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= walk_flt;
                        rsp_paddr <= (walk_flt == FLT_NONE)
                                   ? {pte_ppn(mem_rdata), held.ofs} : '0;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/paged_mmu.sv
`timescale 1ns/1ps
module paged_mmu
    import mmu_pkg::*;
#(
    parameter int unsigned VA_W        = 32,
    parameter int unsigned TLB_ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            req_user,
    output logic            rsp_valid,
    output logic [31:0]     rsp_paddr,
    output logic [1:0]      rsp_fault,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    input  logic            base_we,
    input  logic [31:0]     base_wdata,
    input  logic            base_user,
    output logic            base_fault,
    input  logic            flush
);
    localparam int unsigned VPN_W = VA_W - OFS_W;

    logic [VPN_W-1:0] lk_vpn, fill_vpn;
    logic             tlb_hit, fill_en, base_inval, walk_wait;
    logic [PPN_W-1:0] tlb_ppn, fill_ppn;
    perm_t            tlb_perm, fill_perm;
    logic [31:0]      base;

    mmu_base_reg #(.AW(PTE_W)) i_base (
        .clk(clk), .rst(rst), .wr_en(base_we), .wr_data(base_wdata),
        .wr_user(base_user), .base(base), .inval(base_inval), .reject(base_fault)
    );

    mmu_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W)) i_tlb (
        .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_hit(tlb_hit),
        .lk_ppn(tlb_ppn), .lk_perm(tlb_perm), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush(flush || base_inval)
    );

    mmu_walker #(.VA_W(VA_W)) i_walk (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
        .lk_vpn(lk_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_perm(tlb_perm),
        .base(base), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .walk_wait(walk_wait), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );
endmodule

// File: rtl/mmu_checker.sv
`timescale 1ns/1ps
module mmu_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_fault,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        base_we,
    input logic        base_user,
    input logic        base_fault,
    input logic        walk_wait
);
    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == 32'd0));

    assert_no_code3_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault != 2'd3));

    assert_reject_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(base_fault) |-> $past(base_we && base_user));

    assert_walk_strobe_once_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_walk_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_walk_answer_R3: assert property (@(posedge clk) disable iff (rst)
        (walk_wait && mem_rvalid) |=> rsp_valid);
endmodule

bind paged_mmu mmu_checker i_mmu_checker (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .base_we(base_we),
    .base_user(base_user), .base_fault(base_fault), .walk_wait(walk_wait)
);

// File: tb/test_paged_mmu.sv
`timescale 1ns/1ps
module test_paged_mmu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        base_user = 1'b0;
    logic        base_fault;
    logic        flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] cur_base = '0;

    always #2.5 clk = ~clk;

    paged_mmu i_paged_mmu (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .base_we(base_we), .base_wdata(base_wdata),
        .base_user(base_user), .base_fault(base_fault), .flush(flush)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  kind;
        logic        user;
        logic [1:0]  flt;
        logic        walk;
    } vec_t;

    // kind: 0 read, 1 write, 2 exec; flt: 0 ok, 1 page, 2 protection
    localparam vec_t VEC [12] = '{
        '{32'h0000_2123, 2'd0, 1'b1, 2'd0, 1'b1},
        '{32'h0000_2FFC, 2'd1, 1'b1, 2'd0, 1'b0},
        '{32'h0000_3010, 2'd1, 1'b1, 2'd2, 1'b1},
        '{32'h0000_3444, 2'd0, 1'b1, 2'd0, 1'b0},
        '{32'h0000_1008, 2'd0, 1'b1, 2'd2, 1'b1},
        '{32'h0000_1ABC, 2'd0, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0100, 2'd0, 1'b0, 2'd1, 1'b1},
        '{32'h0000_0200, 2'd0, 1'b0, 2'd1, 1'b1},
        '{32'h0000_4000, 2'd2, 1'b1, 2'd0, 1'b1},
        '{32'h0000_4004, 2'd0, 1'b1, 2'd2, 1'b0},
        '{32'h0000_6FFF, 2'd1, 1'b0, 2'd0, 1'b1},
        '{32'h1234_5678, 2'd1, 1'b1, 2'd0, 1'b1}
    };

    // Page table contents: flags {U,X,W,R,V} by low nibble of the page number.
    function automatic logic [31:0] table_entry(input logic [19:0] vpn);
        logic [4:0] f;
        case (vpn[3:0])
            4'h0:    f = 5'b00000;
            4'h1:    f = 5'b00011;
            4'h2:    f = 5'b10111;
            4'h3:    f = 5'b10011;
            4'h4:    f = 5'b11001;
            4'h6:    f = 5'b00111;
            default: f = 5'b11111;
        endcase
        return {vpn + 20'h40000, 7'h55, f};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic user,
                          output logic [31:0] pa, output logic [1:0] flt,
                          output bit walked, output logic [31:0] maddr);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        walked = 1'b0; maddr = '0; pa = '0; flt = 2'd3;
        if (rsp_valid) begin
            pa = rsp_paddr; flt = rsp_fault;
        end else if (mem_req) begin
            walked = 1'b1;
            maddr  = mem_addr;
            check(req_ready == 1'b0, "R11 ready during walk", 32'(req_ready), 32'd0);
            @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = table_entry(20'((maddr - cur_base) >> 2));
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rsp_valid) begin
                pa = rsp_paddr; flt = rsp_fault;
            end
        end
    endtask

    task automatic expect_acc(input logic [31:0] va, input logic [1:0] kind, input logic user,
                              input logic [1:0] eflt, input bit ewalk, input string tag);
        logic [31:0] pa, maddr, epa;
        logic [1:0]  flt;
        bit          walked;
        access(va, kind, user, pa, flt, walked, maddr);
        epa = (eflt == 2'd0) ? {va[31:12] + 20'h40000, va[11:0]} : 32'd0;
        check(walked == ewalk, {tag, " R2 R4 walk/hit"}, 32'(walked), 32'(ewalk));
        check(flt == eflt, {tag, " R5 R6 fault"}, 32'(flt), 32'(eflt));
        check(pa == epa, {tag, " R1 R7 paddr"}, pa, epa);
        if (walked)
            check(maddr == cur_base + {10'd0, va[31:12], 2'b00}, {tag, " R3 walk addr"},
                  maddr, cur_base + {10'd0, va[31:12], 2'b00});
    endtask

    task automatic write_base(input logic [31:0] v, input logic user);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v; base_user = user;
        @(negedge clk);
        base_we = 1'b0;
        check(base_fault == user, "R10 base_fault pulse", 32'(base_fault), 32'(user));
        if (!user) cur_base = v;
        @(negedge clk);
        check(base_fault == 1'b0, "R10 base_fault clears", 32'(base_fault), 32'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check(req_ready == 1'b1, "R12 req_ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'd0);
        check(mem_req == 1'b0, "R12 mem_req", 32'(mem_req), 32'd0);
        check(base_fault == 1'b0, "R12 base_fault", 32'(base_fault), 32'd0);
        // R12: base is 0 after reset, so the first walk reads near address 0
        expect_acc(32'h0000_5010, 2'd0, 1'b0, 2'd0, 1'b1, "R12 base zero");
        write_base(32'h0010_0000, 1'b0);

        for (int i = 0; i < 12; i++)
            expect_acc(VEC[i].va, VEC[i].kind, VEC[i].user, VEC[i].flt, VEC[i].walk,
                       $sformatf("vec%0d", i));

        // R8: slots now 2,3,1,4,6,12345; fill 7, 8, then 9 evicts page 2
        expect_acc(32'h0000_7000, 2'd0, 1'b0, 2'd0, 1'b1, "R8 fill7");
        expect_acc(32'h0000_8000, 2'd0, 1'b0, 2'd0, 1'b1, "R8 fill8");
        expect_acc(32'h0000_9000, 2'd0, 1'b0, 2'd0, 1'b1, "R8 fill9");
        expect_acc(32'h0000_3008, 2'd0, 1'b1, 2'd0, 1'b0, "R8 page3 kept");
        expect_acc(32'h0000_2008, 2'd0, 1'b1, 2'd0, 1'b1, "R8 page2 evicted");
        expect_acc(32'h0000_3008, 2'd0, 1'b1, 2'd0, 1'b1, "R8 page3 evicted next");

        // R9: flush input empties the cache
        expect_acc(32'h0000_2010, 2'd0, 1'b1, 2'd0, 1'b0, "R9 before flush");
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_acc(32'h0000_2010, 2'd0, 1'b1, 2'd0, 1'b1, "R9 after flush");

        // R10: user write rejected, cache and base untouched
        write_base(32'h0020_0000, 1'b1);
        expect_acc(32'h0000_2020, 2'd0, 1'b1, 2'd0, 1'b0, "R10 user write keeps cache");
        expect_acc(32'h0000_A000, 2'd0, 1'b1, 2'd0, 1'b1, "R10 user write keeps base");
        // R10: supervisor write loads base and empties cache
        write_base(32'h0020_0000, 1'b0);
        expect_acc(32'h0000_2030, 2'd0, 1'b1, 2'd0, 1'b1, "R10 super write new base");
        // R4: invalid entries stay uncached; valid one now hits
        expect_acc(32'h0000_2040, 2'd0, 1'b1, 2'd0, 1'b0, "R4 refill hits");
        expect_acc(32'h0000_0040, 2'd0, 1'b0, 2'd1, 1'b1, "R4 invalid walks again");
        expect_acc(32'h0000_0040, 2'd0, 1'b0, 2'd1, 1'b1, "R5 page fault repeat");

        finish_run();
    end
endmodule